// File: doc/BRIEF.md
# Link Speed Bring-Up Sequencer

This block is the control machine that takes a serial link from reset to a trained state at its lowest rate and then, when the configuration allows it, moves it to the second-generation rate. It does not train the link itself. It programs the link core through a single command channel that carries three kinds of write: the advertised-speed field, the directed-speed-change request, and the PHY receiver override bits. It also drives the core's training-enable level. It watches the core's link-up and speed-change-pending status together with the current-speed status field.

A one-cycle `start` pulse runs the whole sequence. At the end the block raises `done` for one cycle and holds the result until the next start: a link-good flag, the negotiated speed code, and a two-bit error code. Every wait is counted in ticks. A prescaler parameter sets how many clock cycles make one tick, so a bench can shrink the millisecond-scale delays. Any failure ends with a receiver reset pulse sent through the same command channel before `done` is given.

The command channel uses valid/ready. The block raises `cmd_valid` with a fixed `cmd_op`/`cmd_data` pair. It keeps all three unchanged until a cycle in which `cmd_ready` is high, and that cycle is the transfer. The core may hold `cmd_ready` low for any number of cycles. The only effect is that the sequence stalls.

Top module: `link_speed_seq`

## Requirements
- R1: Out of reset `busy`, `done`, `link_ok`, `train_en` and `cmd_valid` are 0 and `err_code` is 0.
- R2: After `start`, the first command is an advertised-speed write (`cmd_op`=0) with data 1 (2.5 GT/s). `train_en` rises only after that write has transferred.
- R3: Once `link_up` is seen, a `max_gen` other than 2 (including 3) ends the run with `link_ok`=1, `err_code`=0, `neg_gen` equal to `cur_speed`, and no speed-change command (`cmd_op`=1).
- R4: With `max_gen`=2, after link-up the block writes the advertised-speed field with data 2 (5.0 GT/s) and then issues one speed-change request (`cmd_op`=1, data 1).
- R5: With `self_clr`=1, `spd_chg_pend` is sampled once every `POLL_TICKS` ticks. After `POLL_MAX` samples that all read 1, the run fails with `err_code`=2.
- R6: With `self_clr`=0 there is no polling, so a `spd_chg_pend` that stays at 1 does not prevent success.
- R7: After the speed-change request, the block waits for `link_up` again. Success reports the `cur_speed` value seen at that moment. If `link_to_ticks` ticks pass without link-up, `err_code` is 3.
- R8: If `link_up` does not appear within `link_to_ticks` ticks of training enable, the run fails with `err_code`=1.
- R9: On any failure, before `done`, the block writes the receiver override (`cmd_op`=2) with data 3 (bit0 data enable, bit1 PLL enable). It then waits `RST_TICKS` ticks and writes the override again with data 0.
- R10: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid`, `cmd_op` and `cmd_data` stay unchanged on the next cycle.
- R11: A `start` that arrives while `busy` is high has no effect on the running sequence.
- R12: `done` is high for exactly one cycle, and `busy` is low on the following cycle. `link_ok`, `neg_gen` and `err_code` hold until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a bring-up run (ignored while busy) |
| max_gen | input | 2 | Highest generation allowed; 2 enables the speed change |
| self_clr | input | 1 | 1 when the core clears the speed-change bit by itself |
| link_to_ticks | input | TW | Link-up timeout in ticks |
| link_up | input | 1 | Link-up status from the core |
| spd_chg_pend | input | 1 | Speed-change request bit read back from the core |
| cur_speed | input | GW | Current link speed status field |
| cmd_valid | output | 1 | Command offered to the core |
| cmd_ready | input | 1 | Core accepts the command this cycle |
| cmd_op | output | 2 | 0 speed field, 1 speed-change request, 2 receiver override |
| cmd_data | output | GW | Command payload |
| train_en | output | 1 | Training enable toward the core |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| link_ok | output | 1 | Last run ended with the link up |
| neg_gen | output | GW | Speed code captured on success |
| err_code | output | 2 | 0 none, 1 training timeout, 2 speed-change stuck, 3 retrain timeout |

## Verification
The assertions are checked on every cycle. They cover the hold rule on the command channel, the single-cycle `done`, the rise of training enable only after the speed-field transfer, the poll counter staying inside its bound, success never appearing together with an error, and success being taken only while link-up is high. Other properties are visible only across a whole scenario, and the bench's link model exercises them. These include the order and payloads of the commands for each mode, the decision between polling and skipping the poll, the three distinct timeouts, the length of the receiver override pulse, the poll window, and the fact that a start in mid-run is ignored.

// File: rtl/lss_pkg.sv
package lss_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_CAP1, S_TRAIN, S_CAP2, S_DSC, S_POLL,
    S_LINK2, S_OSET, S_OWAIT, S_OCLR, S_FIN
  } seq_state_t;

  localparam logic [1:0] OP_SPEED = 2'd0;
  localparam logic [1:0] OP_DSC   = 2'd1;
  localparam logic [1:0] OP_RXOVR = 2'd2;

  localparam logic [1:0] ERR_NONE    = 2'd0;
  localparam logic [1:0] ERR_TRAIN   = 2'd1;
  localparam logic [1:0] ERR_SPDCHG  = 2'd2;
  localparam logic [1:0] ERR_RETRAIN = 2'd3;
endpackage

// File: rtl/lss_tick.sv
module lss_tick #(
  parameter int DIV = 125
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (cnt >= LAST) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end

  assign tick = (cnt >= LAST);
endmodule

// File: rtl/lss_timer.sv
module lss_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          tick,
  input  logic [TW-1:0] limit,
  output logic          expired
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt <= '0;
    else if (clr)                 cnt <= '0;
    else if (tick && cnt != '1)   cnt <= cnt + 1'b1;
  end

  assign expired = (cnt >= limit);

  // R8: time only advances on ticks, so a timeout cannot arrive early
  p_timer_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !tick) |=> $stable(cnt));
endmodule

// File: rtl/lss_fsm.sv
module lss_fsm
  import lss_pkg::*;
#(
  parameter int TW         = 16,
  parameter int GW         = 4,
  parameter int POLL_TICKS = 100,
  parameter int POLL_MAX   = 200,
  parameter int RST_TICKS  = 2500
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    max_gen,
  input  logic          self_clr,
  input  logic [TW-1:0] link_to_ticks,
  input  logic          link_up,
  input  logic          spd_chg_pend,
  input  logic [GW-1:0] cur_speed,
  input  logic          cmd_ready,
  input  logic          tmr_exp,
  output logic          cmd_valid,
  output logic [1:0]    cmd_op,
  output logic [GW-1:0] cmd_data,
  output logic          train_en,
  output logic          busy,
  output logic          done,
  output logic          link_ok,
  output logic [GW-1:0] neg_gen,
  output logic [1:0]    err_code,
  output logic          tmr_clr,
  output logic [TW-1:0] tmr_limit
);
  localparam int AW = $clog2(POLL_MAX + 1);
  localparam logic [AW-1:0] ATT_LAST = AW'(POLL_MAX - 1);
  localparam logic [GW-1:0] SPD_2G5 = GW'(1);
  localparam logic [GW-1:0] SPD_5G0 = GW'(2);

  seq_state_t state, nxt;
  logic [AW-1:0] att;
  logic          fail, ok_set, att_inc, accept;
  logic [1:0]    fail_code;

  assign accept = (state == S_IDLE) && start;

  always_comb begin
    nxt       = state;
    fail      = 1'b0;
    fail_code = ERR_NONE;
    ok_set    = 1'b0;
    att_inc   = 1'b0;
    unique case (state)
      S_IDLE:  if (start) nxt = S_CAP1;
      S_CAP1:  if (cmd_ready) nxt = S_TRAIN;
      S_TRAIN: begin
        if (link_up) begin
          if (max_gen == 2'd2) nxt = S_CAP2;
          else begin nxt = S_FIN; ok_set = 1'b1; end
        end else if (tmr_exp) begin
          fail = 1'b1; fail_code = ERR_TRAIN;
        end
      end
      S_CAP2:  if (cmd_ready) nxt = S_DSC;
      S_DSC:   if (cmd_ready) nxt = self_clr ? S_POLL : S_LINK2;
      S_POLL: begin
        if (tmr_exp) begin
          if (!spd_chg_pend)        nxt = S_LINK2;
          else if (att == ATT_LAST) begin fail = 1'b1; fail_code = ERR_SPDCHG; end
          else                      att_inc = 1'b1;
        end
      end
      S_LINK2: begin
        if (link_up) begin nxt = S_FIN; ok_set = 1'b1; end
        else if (tmr_exp) begin fail = 1'b1; fail_code = ERR_RETRAIN; end
      end
      S_OSET:  if (cmd_ready) nxt = S_OWAIT;
      S_OWAIT: if (tmr_exp) nxt = S_OCLR;
      S_OCLR:  if (cmd_ready) nxt = S_FIN;
      S_FIN:   nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
    if (fail) nxt = S_OSET;
  end

  assign tmr_clr = (nxt != state) || att_inc;

  always_comb begin
    unique case (state)
      S_TRAIN, S_LINK2: tmr_limit = link_to_ticks;
      S_POLL:           tmr_limit = TW'(POLL_TICKS);
      S_OWAIT:          tmr_limit = TW'(RST_TICKS);
      default:          tmr_limit = '0;
    endcase
  end

  always_comb begin
    cmd_valid = 1'b1;
    cmd_op    = OP_SPEED;
    cmd_data  = '0;
    unique case (state)
      S_CAP1:  cmd_data = SPD_2G5;
      S_CAP2:  cmd_data = SPD_5G0;
      S_DSC:   begin cmd_op = OP_DSC;   cmd_data = GW'(1); end
      S_OSET:  begin cmd_op = OP_RXOVR; cmd_data = GW'(3); end
      S_OCLR:  begin cmd_op = OP_RXOVR; cmd_data = '0;     end
      default: cmd_valid = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      att      <= '0;
      train_en <= 1'b0;
      link_ok  <= 1'b0;
      neg_gen  <= '0;
      err_code <= ERR_NONE;
    end else begin
      state <= nxt;
      if (state != S_POLL) att <= '0;
      else if (att_inc)    att <= att + 1'b1;
      if (accept) begin
        train_en <= 1'b0;
        link_ok  <= 1'b0;
        neg_gen  <= '0;
        err_code <= ERR_NONE;
      end else begin
        if (state == S_CAP1 && cmd_ready) train_en <= 1'b1;
        if (ok_set) begin
          link_ok <= 1'b1;
          neg_gen <= cur_speed;
        end
        if (fail) err_code <= fail_code;
      end
    end
  end

  assign busy = (state != S_IDLE);
  assign done = (state == S_FIN);

  // R10: an offered command stays put until it is taken
  p_cmd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_op) && $stable(cmd_data)));

  // R12: completion lasts a single cycle and leaves the block idle
  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  // R2: training begins only after the low-speed field write transferred
  p_train_after_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(train_en) |-> $past(cmd_valid && cmd_ready && cmd_op == OP_SPEED));

  // R5: the poll counter never passes its limit
  p_poll_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    att <= ATT_LAST);

  // R3: success and an error code are never reported together
  p_ok_no_err_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !(link_ok && err_code != ERR_NONE));

  // R11: a start during a run does not drop the run
  p_start_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done && start) |=> busy);
endmodule

// File: rtl/link_speed_seq.sv
module link_speed_seq #(
  parameter int TICK_DIV   = 125,
  parameter int TW         = 16,
  parameter int GW         = 4,
  parameter int POLL_TICKS = 100,
  parameter int POLL_MAX   = 200,
  parameter int RST_TICKS  = 2500
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    max_gen,
  input  logic          self_clr,
  input  logic [TW-1:0] link_to_ticks,
  input  logic          link_up,
  input  logic          spd_chg_pend,
  input  logic [GW-1:0] cur_speed,
  output logic          cmd_valid,
  input  logic          cmd_ready,
  output logic [1:0]    cmd_op,
  output logic [GW-1:0] cmd_data,
  output logic          train_en,
  output logic          busy,
  output logic          done,
  output logic          link_ok,
  output logic [GW-1:0] neg_gen,
  output logic [1:0]    err_code
);
  logic          tick, tmr_clr, tmr_exp;
  logic [TW-1:0] tmr_limit;

  lss_tick #(.DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  lss_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .tick(tick),
    .limit(tmr_limit), .expired(tmr_exp)
  );

  lss_fsm #(
    .TW(TW), .GW(GW), .POLL_TICKS(POLL_TICKS),
    .POLL_MAX(POLL_MAX), .RST_TICKS(RST_TICKS)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .max_gen(max_gen),
    .self_clr(self_clr), .link_to_ticks(link_to_ticks), .link_up(link_up),
    .spd_chg_pend(spd_chg_pend), .cur_speed(cur_speed), .cmd_ready(cmd_ready),
    .tmr_exp(tmr_exp), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .train_en(train_en), .busy(busy), .done(done),
    .link_ok(link_ok), .neg_gen(neg_gen), .err_code(err_code),
    .tmr_clr(tmr_clr), .tmr_limit(tmr_limit)
  );

  // R7: success is only taken while the link reports up
  p_ok_on_link_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_ok) |-> $past(link_up));
endmodule

// File: tb/sim_link_speed_seq.sv
`timescale 1ns/1ps
module sim_link_speed_seq;
  localparam int TD = 4, PT = 3, PM = 8, RT = 10, LTO = 50, TW = 16, GW = 4;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [1:0] max_gen = 2'd1;
  logic self_clr = 1'b0;
  logic [TW-1:0] link_to_ticks = TW'(LTO);
  logic link_up, spd_chg_pend, cmd_ready;
  logic [GW-1:0] cur_speed;
  logic cmd_valid, train_en, busy, done, link_ok;
  logic [1:0] cmd_op, err_code;
  logic [GW-1:0] cmd_data, neg_gen;

  always #4 clk = ~clk;

  link_speed_seq #(.TICK_DIV(TD), .TW(TW), .GW(GW), .POLL_TICKS(PT),
                   .POLL_MAX(PM), .RST_TICKS(RT)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .max_gen(max_gen),
    .self_clr(self_clr), .link_to_ticks(link_to_ticks), .link_up(link_up),
    .spd_chg_pend(spd_chg_pend), .cur_speed(cur_speed), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_data(cmd_data),
    .train_en(train_en), .busy(busy), .done(done), .link_ok(link_ok),
    .neg_gen(neg_gen), .err_code(err_code)
  );

  int n_tests = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // {max_gen[15:14], self_clr, partner_up, partner_gen2, pend_sticky,
  //  retrain_ok, backpressure, exp_ok, exp_err[6:5], exp_gen[4:1], exp_dsc}
  localparam logic [15:0] VEC [8] = '{
    {2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 4'd1, 1'b0},
    {2'd2, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 2'd0, 4'd2, 1'b1},
    {2'd2, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 2'd0, 4'd1, 1'b1},
    {2'd2, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd2, 4'd0, 1'b1},
    {2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd1, 4'd0, 1'b0},
    {2'd2, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd3, 4'd0, 1'b1},
    {2'd2, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 2'd0, 4'd2, 1'b1},
    {2'd3, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 2'd0, 4'd1, 1'b0}
  };

  // link partner model
  logic m_allow = 1'b0, m_g2 = 1'b0, m_sticky = 1'b0, m_rok = 1'b0, m_bp = 1'b0;
  logic m_trained, m_retrain;
  logic [GW-1:0] m_cap;
  int m_up_cnt, m_rcnt, m_pcnt, m_cyc;

  initial begin
    link_up = 0; spd_chg_pend = 0; cur_speed = 0; cmd_ready = 0;
    m_trained = 0; m_retrain = 0; m_cap = 0;
    m_up_cnt = 0; m_rcnt = 0; m_pcnt = 0; m_cyc = 0;
    forever begin
      @(posedge clk);
      m_cyc <= m_cyc + 1;
      cmd_ready <= m_bp ? (m_cyc % 4 == 0) : 1'b1;
      if (start && !busy) begin
        link_up <= 0; spd_chg_pend <= 0; cur_speed <= 0; m_cap <= 0;
        m_trained <= 0; m_up_cnt <= 0; m_retrain <= 0; m_rcnt <= 0; m_pcnt <= 0;
      end else begin
        if (cmd_valid && cmd_ready && cmd_op == 2'd0) m_cap <= cmd_data;
        if (train_en && !m_trained && m_allow) begin
          m_up_cnt <= m_up_cnt + 1;
          if (m_up_cnt == 11) begin link_up <= 1; cur_speed <= 1; m_trained <= 1; end
        end
        if (spd_chg_pend && !m_sticky) begin
          m_pcnt <= m_pcnt + 1;
          if (m_pcnt == 19) spd_chg_pend <= 0;
        end
        if (m_retrain) begin
          m_rcnt <= m_rcnt + 1;
          if (m_rcnt == 29 && m_rok) begin link_up <= 1; cur_speed <= 2; m_retrain <= 0; end
        end
        if (cmd_valid && cmd_ready && cmd_op == 2'd1) begin
          spd_chg_pend <= 1; m_pcnt <= 0;
          if (m_g2 && m_cap == 2) begin link_up <= 0; m_retrain <= 1; m_rcnt <= 0; end
        end
      end
    end
  end

  // observer of the command channel, sampled mid-cycle
  int cyc = 0, n_cap, n_dsc, n_ovr, n_done, t_dsc, t_oset, t_oclr;
  int cap_first, cap_second, ovr_first, ovr_second;
  bit train_early;

  initial forever begin
    @(negedge clk);
    cyc++;
    if (start && !busy) begin
      n_cap = 0; n_dsc = 0; n_ovr = 0; n_done = 0; t_dsc = 0; t_oset = 0; t_oclr = 0;
      cap_first = -1; cap_second = -1; ovr_first = -1; ovr_second = -1; train_early = 0;
    end else begin
      if (train_en && n_cap == 0) train_early = 1;
      if (cmd_valid && cmd_op == 2'd2 && cmd_data == 0 && n_ovr == 1 && t_oclr == 0)
        t_oclr = cyc;
      if (cmd_valid && cmd_ready) begin
        case (cmd_op)
          2'd0: begin if (n_cap == 0) cap_first = cmd_data; else cap_second = cmd_data; n_cap++; end
          2'd1: begin n_dsc++; t_dsc = cyc; end
          2'd2: begin
            if (n_ovr == 0) begin ovr_first = cmd_data; t_oset = cyc; end
            else ovr_second = cmd_data;
            n_ovr++;
          end
          default: ;
        endcase
      end
      if (done) n_done++;
    end
  end

  task automatic pulse_start();
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
  endtask

  task automatic wait_done(output bit seen);
    seen = 0;
    for (int w = 0; w < 4000; w++) begin
      @(negedge clk);
      if (done) begin seen = 1; break; end
    end
  endtask

  task automatic run_vec(input int i);
    logic [15:0] v;
    bit seen;
    v = VEC[i];
    max_gen = v[15:14]; self_clr = v[13]; m_allow = v[12]; m_g2 = v[11];
    m_sticky = v[10]; m_rok = v[9]; m_bp = v[8];
    pulse_start();
    wait_done(seen);
    chk(seen, "R12 done reached", seen, 1);
    repeat (6) @(negedge clk);
    chk(cap_first == 1, "R2 first speed write data", cap_first, 1);
    chk(!train_early, "R2 train_en after speed write", train_early, 0);
    chk(link_ok == v[7], "R3/R7 link_ok", link_ok, v[7]);
    chk(err_code == v[6:5], "R5/R7/R8 err_code", err_code, v[6:5]);
    if (v[7]) chk(neg_gen == v[4:1], "R3/R7 neg_gen", neg_gen, v[4:1]);
    chk(n_dsc == v[0], "R3/R4 speed-change count", n_dsc, v[0]);
    if (v[0]) chk(n_cap == 2 && cap_second == 2, "R4 second speed write", cap_second, 2);
    else      chk(n_cap == 1, "R3 single speed write", n_cap, 1);
    chk(n_done == 1, "R12 done width", n_done, 1);
    chk(!busy && !done, "R12 idle after done", busy, 0);
    if (v[6:5] != 0) begin
      chk(n_ovr == 2 && ovr_first == 3, "R9 override set", ovr_first, 3);
      chk(ovr_second == 0, "R9 override clear", ovr_second, 0);
      chk(t_oclr - t_oset >= (RT - 1) * TD && t_oclr - t_oset <= RT * TD + 4,
          "R9 override hold", t_oclr - t_oset, RT * TD);
    end else begin
      chk(n_ovr == 0, "R9 no override on success", n_ovr, 0);
    end
    if (v[6:5] == 2) begin
      chk(t_oset - t_dsc >= PM * (PT - 1) * TD && t_oset - t_dsc <= PM * (PT * TD + 2) + 4,
          "R5 poll window", t_oset - t_dsc, PM * PT * TD);
    end
    if (v[13] == 0 && v[10] == 1)
      chk(link_ok && err_code == 0, "R6 no poll with sticky bit", err_code, 0);
    if (v[8])
      chk(link_ok, "R10 back-pressure run completes", link_ok, 1);
  endtask

  initial begin
    bit seen;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !link_ok && !train_en && !cmd_valid && err_code == 0,
        "R1 reset state", {busy, done, link_ok, train_en, cmd_valid}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!busy && !cmd_valid && !train_en, "R1 idle after reset", busy, 0);

    for (int i = 0; i < 8; i++) run_vec(i);

    // R11: a second start in the middle of a gen2 run is ignored
    max_gen = 2'd2; self_clr = 1'b1; m_allow = 1; m_g2 = 1; m_sticky = 0; m_rok = 1; m_bp = 0;
    pulse_start();
    repeat (30) @(negedge clk);
    chk(busy, "R11 busy mid-run", busy, 1);
    pulse_start();
    wait_done(seen);
    repeat (4) @(negedge clk);
    chk(n_cap == 2 && cap_first == 1, "R11 no restart speed writes", n_cap, 2);
    chk(link_ok && neg_gen == 2, "R11 run unaffected", neg_gen, 2);

    // R8: a shorter programmed timeout still fails with the training code
    link_to_ticks = TW'(5); max_gen = 2'd1; m_allow = 0;
    pulse_start();
    wait_done(seen);
    chk(seen && err_code == 1, "R8 short timeout", err_code, 1);
    // R12: result cleared by next accepted start, then held
    link_to_ticks = TW'(LTO); m_allow = 1;
    pulse_start();
    repeat (2) @(negedge clk);
    chk(err_code == 0 && !link_ok, "R12 result cleared on start", err_code, 0);
    wait_done(seen);
    repeat (10) @(negedge clk);
    chk(link_ok && neg_gen == 1, "R12 result held", link_ok, 1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(8 * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule